// File: doc/BRIEF.md
# Vector Find-Element-Equal Unit

This unit takes two 128-bit operands and compares them element by element. Element k of the first operand is compared only with element k of the second. Elements can be 8, 16 or 32 bits wide. The unit returns the byte offset of the lowest-numbered element position where the two operands hold equal values.

When its zero-search control bit is set, the unit also looks for the first all-zero element of the first operand. It then reports whichever of the two events comes first. A 2-bit condition code states which event was found, and which came first when both are present.

The result is a 128-bit vector. The offset sits in the low doubleword (bits 63:0) and the high doubleword is always zero. Result and condition code are registered. They appear one cycle after an accepted request.

Top module: `vfind_eq`

## Requirements
- R1: `elem_size` selects the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Code 3 behaves exactly like code 2.
- R2: Element 0 occupies the most significant bits of each operand (bits 127 downward). Element k of `opa` is compared only with element k of `opb`. The reported offset is k times the element width in bytes.
- R3: `result[63:0]` holds the reported byte offset and `result[127:64]` is always zero.
- R4: If no equal element is found, the equal-search offset is 16. If zero-search is off or no zero element exists, the zero-search offset is 16.
- R5: `ctrl[1]` enables zero-search. Then the reported offset is the smaller of the first-equal offset and the first-zero-in-`opa` offset. A zero element must have every one of its bytes zero. The other `ctrl` bits have no effect.
- R6: `cc` is 3 when both searches give 16. It is 1 when an equal element exists and no zero was found. It is 2 when the first equal element lies strictly before the first zero.
- R7: `cc` is 0 whenever a zero element lies at or before the first equal element, including the case where both fall at the same position.
- R8: `out_valid` is `in_valid` delayed by one clock. `result` and `cc` update only on a cycle with `in_valid` high and hold otherwise.
- R9: A synchronous active-high `rst` clears `out_valid`, `result` and `cc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| elem_size | input | 2 | Element width code |
| ctrl | input | 4 | Control field; bit 1 enables zero-search |
| opa | input | 128 | First operand (searched for zeros) |
| opb | input | 128 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Byte offset in low doubleword, zero above |
| cc | output | 2 | Condition code |

## Verification
The bench checks wide elements whose first byte matches while a later byte differs. A design that tested bytes instead of whole elements would report offset 0 there. For 16-bit elements it uses operands that contain zero bytes but no zero element, so a byte-level zero detector would report a false terminator. It checks a tie between the equal and zero positions, which must give code 0 rather than 2, and it checks that the control bits beside bit 1 leave the zero search off. Size code 3 and result hold without a request are also checked, so a wrong size decode or a register that loads on every clock shows up.

// File: rtl/vfind_eq.sv
module vfind_eq #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    elem_size,
  input  logic [3:0]    ctrl,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic [1:0]    cc
);
  localparam int NB = VW / 8;
  localparam int IW = $clog2(NB) + 1;

  logic [NB-1:0] beq, bz, heq, hz;
  logic [IW-1:0] fe, fz, idx, idx_q;
  logic [1:0]    cc_n, cc_q;
  logic          zs;

  assign zs = ctrl[1];

  for (genvar j = 0; j < NB; j++) begin : g_byte
    localparam int J2 = j - (j % 2);
    localparam int J4 = j - (j % 4);
    assign beq[j] = opa[VW-1-8*j -: 8] == opb[VW-1-8*j -: 8];
    assign bz[j]  = opa[VW-1-8*j -: 8] == 8'h00;
    always_comb begin
      case (elem_size)
        2'd0:    begin heq[j] = beq[j];              hz[j] = bz[j]; end
        2'd1:    begin heq[j] = &beq[J2+1:J2];       hz[j] = &bz[J2+1:J2]; end
        default: begin heq[j] = &beq[J4+3:J4];       hz[j] = &bz[J4+3:J4]; end
      endcase
    end
  end

  function automatic logic [IW-1:0] first_set(input logic [NB-1:0] v);
    first_set = IW'(NB);
    for (int i = NB - 1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  assign fe  = first_set(heq);
  assign fz  = first_set(hz & {NB{zs}});
  assign idx = (fe < fz) ? fe : fz;

  always_comb begin
    if (fe == IW'(NB) && fz == IW'(NB)) cc_n = 2'd3;
    else if (fz == IW'(NB))             cc_n = 2'd1;
    else if (fe < fz)                   cc_n = 2'd2;
    else                                cc_n = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      idx_q     <= '0;
      cc_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        idx_q <= idx;
        cc_q  <= cc_n;
      end
    end
  end

  assign result = {{(VW-IW){1'b0}}, idx_q};
  assign cc     = cc_q;
endmodule

// File: rtl/vfind_eq_chk.sv
module vfind_eq_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    elem_size,
  input logic [3:0]    ctrl,
  input logic [VW-1:0] opa,
  input logic [VW-1:0] opb,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic [1:0]    cc
);
  localparam int NB = VW / 8;

  a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(cc)));

  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[63:0] <= 64'(NB));

  a_r6_none_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((cc == 2'd3) == (result[63:0] == 64'(NB))));

  a_r5_zs_off: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst) && !$past(ctrl[1])) |-> (cc == 2'd1 || cc == 2'd3));

  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst) && $past(elem_size) != 2'd0) |-> result[0] == 1'b0);
endmodule

bind vfind_eq vfind_eq_chk #(.VW(VW)) chk (.*);

// File: tb/vfind_eq_test.sv
module vfind_eq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]   sz;
    logic [3:0]   ctl;
    logic [127:0] a;
    logic [127:0] b;
    logic [4:0]   idx;
    logic [1:0]   code;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'h0, 128'h0102030405060708090a0b0c0d0e0f10, 128'hffffffffff06ffffffffffffffffffff, 5'd5,  2'd1},
    '{2'd0, 4'h0, 128'h0102030405060708090a0b0c0d0e0f10, 128'h1112131415161718191a1b1c1d1e1f20, 5'd16, 2'd3},
    '{2'd1, 4'h0, 128'h11112222333344445555666677778888, 128'h11002200333300000000000000000000, 5'd4,  2'd1},
    '{2'd2, 4'h0, 128'haabbccdd112233445566778899aabbcc, 128'haabbcc00112233440000000000000000, 5'd4,  2'd1},
    '{2'd0, 4'h2, 128'h0102030005060708090a0b0c0d0e0f10, 128'hffffffffffffff08ffffffffffffffff, 5'd3,  2'd0},
    '{2'd0, 4'h2, 128'h010203040506070809000b0c0d0e0f10, 128'hffff03ffffffffffffffffffffffffff, 5'd2,  2'd2},
    '{2'd0, 4'h2, 128'h0102030400060708090a0b0c0d0e0f10, 128'hffffffff00ffffffffffffffffffffff, 5'd4,  2'd0},
    '{2'd1, 4'h2, 128'h01000200030004000500060007000800, 128'hffffffffffffffffffffffffffffffff, 5'd16, 2'd3},
    '{2'd2, 4'h2, 128'h11111111222222223333333300000000, 128'hffffffffffffffffffffffffffffffff, 5'd12, 2'd0},
    '{2'd3, 4'h0, 128'haabbccdd112233445566778899aabbcc, 128'haabbcc00112233440000000000000000, 5'd4,  2'd1},
    '{2'd0, 4'hd, 128'h0102030005060708090a0b0c0d0e0f10, 128'hffffffffffffff08ffffffffffffffff, 5'd7,  2'd1},
    '{2'd1, 4'h2, 128'h0,                                128'h0,                                5'd0,  2'd0},
    '{2'd2, 4'h2, 128'h12345678aaaaaaaa00000000bbbbbbbb, 128'h12345678ffffffffffffffffffffffff, 5'd0,  2'd2}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] elem_size = '0;
  logic [3:0] ctrl = '0;
  logic [127:0] opa = '0, opb = '0;
  logic out_valid;
  logic [127:0] result;
  logic [1:0] cc;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  vfind_eq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] s, input logic [3:0] c, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    elem_size = s; ctrl = c; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", 128'(out_valid), 128'd0);
    check("R9 reset result", result, 128'd0);
    check("R9 reset cc", 128'(cc), 128'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].sz, TBL[i].ctl, TBL[i].a, TBL[i].b);
      check($sformatf("R1 R2 R4 R5 vec%0d out_valid (R8)", i), 128'(out_valid), 128'd1);
      check($sformatf("R3 R4 R5 vec%0d index", i), result, 128'(TBL[i].idx));
      check($sformatf("R6 R7 vec%0d cc", i), 128'(cc), 128'(TBL[i].code));
    end

    // R8: no request -> valid drops, result held while inputs change
    @(negedge clk);
    elem_size = 2'd0; ctrl = 4'h2; opa = '0; opb = '0;
    @(negedge clk);
    check("R8 out_valid low", 128'(out_valid), 128'd0);
    check("R8 result held", result, 128'd0);
    check("R8 cc held", 128'(cc), 128'd2);

    // R3: upper doubleword zero on a nonzero offset
    issue(2'd0, 4'h0, 128'h0102030405060708090a0b0c0d0e0f10, 128'hffffffffffffffffffffffffffffff10);
    check("R3 upper doubleword", 128'(result[127:64]), 128'd0);
    check("R2 last byte offset", 128'(result[63:0]), 128'd15);

    // R9: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 midrun out_valid", 128'(out_valid), 128'd0);
    check("R9 midrun result", result, 128'd0);
    check("R9 midrun cc", 128'(cc), 128'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule